// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block runs the external bus of a small 8-bit microcontroller core. The core asks for one of three operations: an instruction fetch from program memory, a load from data memory, or a store to data memory. The block then drives a bus cycle of fixed length. The low address byte and the data byte share one bidirectional port. The high address byte has a port of its own. An external transparent latch holds the low address. The block pulses an address strobe for that latch. It then either releases the shared port to receive data or drives the store data onto it.

Fetches are short, six clocks long, and are timed by a program-store strobe. Data accesses take twelve clocks and use a separate read strobe and write strobe. Every strobe is active-low. After each cycle the shared port is released. The high port goes back to the value that the core's port latch holds. The core sees the controller as free through `req_ready`. Fetched bytes and loaded bytes come back as a single-clock response pulse.

The sequencer moves through five named states. IDLE goes to ADDR when a request is accepted. ADDR goes to HOLD when the address-strobe time has elapsed. HOLD goes to STROBE when the address hold time has elapsed. STROBE goes to RECOVER when the strobe time has elapsed. RECOVER goes back to IDLE. Each state has its own duration, and the duration depends on whether the cycle is a fetch or a data cycle.

Top module: `ebus_ctrl`

## Requirements
- R1: During reset and whenever idle, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `ad_oe` is 0 and `req_ready` is 1.
- R2: A request is taken only on a clock edge where `req_ready` is 1 and `req_valid` is 1. While a cycle runs, `req_ready` is 0, and changes on `req_valid`, `req_kind`, `req_addr` or `req_wdata` have no effect on that cycle. A request held high during a cycle is taken on the first edge after the controller returns to idle.
- R3: A fetch (`req_kind` = 0) lasts 6 clocks after it is taken. `ale` is 1 in clocks 1 and 2. The low address is driven in clocks 1 to 3. `psen_n` is 0 in clocks 4 and 5. Clock 6 is recovery.
- R4: A load (`req_kind` = 1, and also code 3) or a store (`req_kind` = 2) lasts 12 clocks. `ale` is 1 in clocks 1 and 2. The low address is driven in clocks 1 to 4. The strobe is 0 in clocks 5 to 10. Clocks 11 and 12 are recovery.
- R5: Fetches use only `psen_n`, loads use only `rd_n` and stores use only `wr_n`. At most one strobe is low at any time.
- R6: `ale` falls while the low address is still driven and unchanged. `ale` is never 1 while any strobe is low.
- R7: For fetches and loads, `ad_in` is captured on the clock edge where the strobe rises. `rsp_valid` is then 1 for exactly the next clock, carrying the captured byte on `rsp_data`. Stores give no response.
- R8: During a store, `ad_out` carries `req_wdata` with `ad_oe` = 1 for every clock in which `wr_n` is 0. While `psen_n` or `rd_n` is 0, and during recovery, `ad_oe` is 0.
- R9: While a cycle runs, `hi_out` equals the high byte of the accepted address. When idle, `hi_out` follows `hi_latch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core requests a bus cycle |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 load |
| req_addr | input | 16 | Full external address |
| req_wdata | input | 8 | Store data |
| req_ready | output | 1 | Controller idle, request can be taken |
| rsp_valid | output | 1 | One-clock pulse with fetched or loaded byte |
| rsp_data | output | 8 | Fetched or loaded byte |
| hi_latch | input | 8 | Core's high-port latch value |
| ale | output | 1 | Address latch strobe, active-high |
| psen_n | output | 1 | Program-store enable, active-low |
| rd_n | output | 1 | Data read strobe, active-low |
| wr_n | output | 1 | Data write strobe, active-low |
| ad_out | output | 8 | Shared port output: low address or store data |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port input |
| hi_out | output | 8 | High address port |

## Verification
Each operation kind is run at both address extremes and at mixed bit patterns. A model of the external memory captures the low byte at the falling edge of `ale` and answers with a byte derived from the captured address. A wrong latch capture therefore appears as wrong response data.

Requests issued back to back, with `req_valid` held and the fields scrambled during the cycle, separate correct wait-for-idle behaviour from early acceptance. Changes on `hi_latch` between cycles confirm that the high port is restored rather than left at the address. Code 3 is also tried, to confirm that it takes the load timing.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_LOAD  = 2'd1,
        KIND_STORE = 2'd2,
        KIND_ALT   = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLD,
        ST_STROBE,
        ST_RECOVER
    } state_e;

endpackage

// File: rtl/ebus_seq.sv
module ebus_seq
    import ebus_pkg::*;
#(
    parameter int P_ALE = 2,
    parameter int P_HLD = 1,
    parameter int P_STB = 2,
    parameter int P_REC = 1,
    parameter int D_ALE = 2,
    parameter int D_HLD = 2,
    parameter int D_STB = 6,
    parameter int D_REC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_kind,
    output logic       accept,
    output logic       busy,
    output logic       sample,
    output logic       sel_data,
    output logic       ale,
    output logic       psen_n,
    output logic       rd_n,
    output logic       wr_n,
    output logic       ad_oe
);

    localparam int MAX_P = (P_ALE > P_HLD ? P_ALE : P_HLD) > (P_STB > P_REC ? P_STB : P_REC)
                         ? (P_ALE > P_HLD ? P_ALE : P_HLD) : (P_STB > P_REC ? P_STB : P_REC);
    localparam int MAX_D = (D_ALE > D_HLD ? D_ALE : D_HLD) > (D_STB > D_REC ? D_STB : D_REC)
                         ? (D_ALE > D_HLD ? D_ALE : D_HLD) : (D_STB > D_REC ? D_STB : D_REC);
    localparam int MAX_L = MAX_P > MAX_D ? MAX_P : MAX_D;
    localparam int CNT_W = $clog2(MAX_L + 1);

    state_e           state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    kind_e            kind_q, kind_n;

    function automatic logic [CNT_W-1:0] span(input state_e s, input logic prog);
        int n;
        unique case (s)
            ST_ADDR:    n = prog ? P_ALE : D_ALE;
            ST_HOLD:    n = prog ? P_HLD : D_HLD;
            ST_STROBE:  n = prog ? P_STB : D_STB;
            ST_RECOVER: n = prog ? P_REC : D_REC;
            default:    n = 1;
        endcase
        return CNT_W'(n - 1);
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            kind_q <= KIND_FETCH;
        end else begin
            state  <= state_n;
            cnt    <= cnt_n;
            kind_q <= kind_n;
        end
    end

    // transitions
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        kind_n  = kind_q;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    state_n = ST_ADDR;
                    kind_n  = kind_e'(req_kind);
                    cnt_n   = span(ST_ADDR, kind_e'(req_kind) == KIND_FETCH);
                end
            end
            ST_ADDR: begin
                if (cnt == '0) begin
                    state_n = ST_HOLD;
                    cnt_n   = span(ST_HOLD, kind_q == KIND_FETCH);
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt == '0) begin
                    state_n = ST_STROBE;
                    cnt_n   = span(ST_STROBE, kind_q == KIND_FETCH);
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            ST_STROBE: begin
                if (cnt == '0) begin
                    state_n = ST_RECOVER;
                    cnt_n   = span(ST_RECOVER, kind_q == KIND_FETCH);
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            ST_RECOVER: begin
                if (cnt == '0) begin
                    state_n = ST_IDLE;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            default: begin
                state_n = ST_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        logic strobing, is_prog, is_store;
        strobing = (state == ST_STROBE);
        is_prog  = (kind_q == KIND_FETCH);
        is_store = (kind_q == KIND_STORE);
        accept   = (state == ST_IDLE) && req_valid;
        busy     = (state != ST_IDLE);
        ale      = (state == ST_ADDR);
        psen_n   = !(strobing && is_prog);
        rd_n     = !(strobing && !is_prog && !is_store);
        wr_n     = !(strobing && is_store);
        sel_data = strobing && is_store;
        ad_oe    = (state == ST_ADDR) || (state == ST_HOLD) || (strobing && is_store);
        sample   = strobing && (cnt == '0) && !is_store;
    end

endmodule

// File: rtl/ebus_datapath.sv
module ebus_datapath #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic                 busy,
    input  logic                 sample,
    input  logic                 sel_data,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [ADDR_W-DATA_W-1:0] hi_latch,
    input  logic [DATA_W-1:0]    ad_in,
    output logic [DATA_W-1:0]    ad_out,
    output logic [ADDR_W-DATA_W-1:0] hi_out,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_data
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            rsp_valid <= sample;
            if (sample) begin
                rsp_data <= ad_in;
            end
        end
    end

    assign ad_out = sel_data ? wdata_q : addr_q[DATA_W-1:0];
    assign hi_out = busy ? addr_q[ADDR_W-1 -: HI_W] : hi_latch;

endmodule

// File: rtl/ebus_ctrl.sv
module ebus_ctrl
    import ebus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int P_ALE  = 2,
    parameter int P_HLD  = 1,
    parameter int P_STB  = 2,
    parameter int P_REC  = 1,
    parameter int D_ALE  = 2,
    parameter int D_HLD  = 2,
    parameter int D_STB  = 6,
    parameter int D_REC  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [1:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_ready,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_data,
    input  logic [ADDR_W-DATA_W-1:0] hi_latch,
    output logic                     ale,
    output logic                     psen_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] hi_out
);

    logic accept, busy, sample, sel_data;

    ebus_seq #(
        .P_ALE(P_ALE), .P_HLD(P_HLD), .P_STB(P_STB), .P_REC(P_REC),
        .D_ALE(D_ALE), .D_HLD(D_HLD), .D_STB(D_STB), .D_REC(D_REC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_kind (req_kind),
        .accept   (accept),
        .busy     (busy),
        .sample   (sample),
        .sel_data (sel_data),
        .ale      (ale),
        .psen_n   (psen_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .ad_oe    (ad_oe)
    );

    ebus_datapath #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .busy     (busy),
        .sample   (sample),
        .sel_data (sel_data),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .hi_latch (hi_latch),
        .ad_in    (ad_in),
        .ad_out   (ad_out),
        .hi_out   (hi_out),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data)
    );

    assign req_ready = !busy;

endmodule

// File: rtl/ebus_ctrl_chk.sv
module ebus_ctrl_chk #(
    parameter int DATA_W = 8,
    parameter int HI_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              ale,
    input logic              psen_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic              ad_oe,
    input logic [DATA_W-1:0] ad_out,
    input logic [HI_W-1:0]   hi_latch,
    input logic [HI_W-1:0]   hi_out
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!ale && psen_n && rd_n && wr_n && !ad_oe)); // R1

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!psen_n, !rd_n, !wr_n}) <= 1); // R5

    AST_ALE_APART: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (psen_n && rd_n && wr_n)); // R6

    AST_ALE_FALL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (ad_oe && $stable(ad_out))); // R6

    AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (!psen_n || !rd_n) |-> !ad_oe); // R8

    AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe); // R8

    AST_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && $past(!wr_n)) |-> $stable(ad_out)); // R8

    AST_RSP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(!psen_n || !rd_n) && psen_n && rd_n)); // R7

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R7

    AST_HI_RESTORED: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (hi_out == hi_latch)); // R9

endmodule

bind ebus_ctrl ebus_ctrl_chk #(.DATA_W(DATA_W), .HI_W(ADDR_W - DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .ale      (ale),
    .psen_n   (psen_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .ad_oe    (ad_oe),
    .ad_out   (ad_out),
    .hi_latch (hi_latch),
    .hi_out   (hi_out)
);

// File: tb/tb_ebus_ctrl.sv
module tb_ebus_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_data;
    logic [7:0]  hi_latch = 8'h00;
    logic        ale, psen_n, rd_n, wr_n, ad_oe;
    logic [7:0]  ad_out, ad_in, hi_out;
    logic [7:0]  lat_lo = 8'h00;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    ebus_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .hi_latch(hi_latch),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .hi_out(hi_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // external latch and memory model
    always @(negedge ale) lat_lo = ad_out;
    assign ad_in = (!psen_n || !rd_n) ? (lat_lo ^ hi_out ^ 8'hA5) : 8'h00;

    // behavioural reference model
    bit          m_act = 0;
    int          m_t = 0;
    int          m_accepts = 0;
    logic [1:0]  m_kind = 0;
    logic [15:0] m_addr = 0;
    logic [7:0]  m_wd = 0;

    function automatic int kind_len(input logic [1:0] k);
        return (k == 2'd0) ? 6 : 12;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0;
            m_t   = 0;
        end else if (m_act) begin
            if (m_t == kind_len(m_kind)) m_act = 0;
            else m_t++;
        end else if (req_valid) begin
            m_act  = 1;
            m_t    = 1;
            m_kind = req_kind;
            m_addr = req_addr;
            m_wd   = req_wdata;
            m_accepts++;
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            bit fetch, store, load;
            bit e_ale, e_oe, e_psn, e_rdn, e_wrn, e_rsp;
            logic [7:0] e_ad;
            string ttag;
            fetch = m_act && (m_kind == 2'd0);
            store = m_act && (m_kind == 2'd2);
            load  = m_act && !fetch && !store;
            ttag  = fetch ? "R3" : "R4";
            e_ale = m_act && (m_t <= 2);
            e_oe  = (fetch && m_t <= 3) || ((load || store) && m_t <= 4) ||
                    (store && m_t >= 5 && m_t <= 10);
            e_ad  = (store && m_t >= 5) ? m_wd : m_addr[7:0];
            e_psn = !(fetch && (m_t == 4 || m_t == 5));
            e_rdn = !(load && m_t >= 5 && m_t <= 10);
            e_wrn = !(store && m_t >= 5 && m_t <= 10);
            e_rsp = (fetch && m_t == 6) || (load && m_t == 11);
            check(m_act ? "R2" : "R1", "req_ready", req_ready, !m_act);
            check(m_act ? ttag : "R1", "ale", ale, e_ale);
            check("R5", "psen_n", psen_n, e_psn);
            check("R5", "rd_n", rd_n, e_rdn);
            check("R5", "wr_n", wr_n, e_wrn);
            check("R8", "ad_oe", ad_oe, e_oe);
            if (e_oe) check(e_ale ? "R6" : "R8", "ad_out", ad_out, e_ad);
            check("R9", "hi_out", hi_out, m_act ? m_addr[15:8] : hi_latch);
            check("R7", "rsp_valid", rsp_valid, e_rsp);
            if (e_rsp) check("R7", "rsp_data", rsp_data, m_addr[7:0] ^ m_addr[15:8] ^ 8'hA5);
        end
    end

    task automatic issue(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d,
                         input bit keep);
        int n0;
        n0 = m_accepts;
        @(posedge clk); #1;
        req_valid = 1'b1;
        req_kind  = k;
        req_addr  = a;
        req_wdata = d;
        do begin
            @(posedge clk); #1;
        end while (m_accepts == n0);
        // R2: scramble fields mid-cycle; they must have no effect
        req_addr  = ~a;
        req_wdata = ~d;
        req_kind  = 2'd2 - k[0];
        if (!keep) req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_act) begin
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "reset ale", ale, 0);
        check("R1", "reset strobes", {psen_n, rd_n, wr_n}, 3'b111);
        check("R1", "reset ad_oe", ad_oe, 0);
        check("R1", "reset req_ready", req_ready, 1);
        rst_n = 1'b1;
        hi_latch = 8'h5A;
        repeat (2) @(posedge clk);
        #1;
        issue(2'd0, 16'h1234, 8'h00, 0); wait_idle();       // R3 fetch
        issue(2'd1, 16'hABCD, 8'h00, 0); wait_idle();       // R4 load
        issue(2'd2, 16'h00FF, 8'h3C, 0); wait_idle();       // R8 store
        hi_latch = 8'hC3;                                   // R9 restore
        repeat (2) @(posedge clk);
        #1;
        issue(2'd0, 16'hFFFF, 8'h00, 0); wait_idle();
        issue(2'd1, 16'h0000, 8'h00, 0); wait_idle();
        issue(2'd3, 16'h8001, 8'h00, 0); wait_idle();       // R4 code 3 as load
        // R2: back-to-back requests with valid held
        issue(2'd0, 16'h4321, 8'h00, 1);
        issue(2'd1, 16'h7E81, 8'h00, 1);
        issue(2'd2, 16'hC0DE, 8'hF0, 0);
        wait_idle();
        issue(2'd2, 16'h5555, 8'hAA, 1);
        issue(2'd0, 16'hAAAA, 8'h00, 0);
        wait_idle();
        hi_latch = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule